// File: doc/BRIEF.md
# Ethernet receive destination filter

This block decides, for each received frame, whether it is kept or discarded. The decision uses the six destination address bytes, the frame length and a set of static configuration inputs. The frame's payload never passes through the block. A frame is described by a one-cycle `frm_valid` strobe carrying its destination and length. One cycle later the block returns a registered verdict, a runt flag and the frame's address class.

Filtering runs in two stages, one after the other. The first stage is an exact-match stage: a station address for unicast frames, reject switches for broadcast and multicast frames, and a small table of multicast addresses. Promiscuous mode skips this stage. The second stage is optional and needs two enables. It compares unicast frames against a second station address and looks multicast frames up in a 32768-bit hash bitmap, held as 1024 words of 32 bits. Receive gating, oversize handling for frames without jumbo or VLAN support, and a runt check with a sticky status bit complete the verdict.

Top module: `rx_addr_filter`

## Requirements
- R1: Each presented frame is classed as exactly one of unicast, broadcast or multicast. `frm_dst[7:0]` is destination byte 0 and `frm_dst[8k+7:8k]` is byte k. A frame is unicast when bit 0 of byte 0 is 0. It is broadcast when all six bytes are 0xFF. Every other frame is multicast. `cls_ipmc` is set only for a multicast frame whose bytes 0,1,2 are 0x01,0x00,0x52.
- R2: With `promisc` high the first stage passes every frame. The second stage, oversize, runt and gating rules still apply.
- R3: In the first stage a unicast frame passes only if `{sta_hi,sta_lo}` equals `frm_dst`. `sta_lo[7:0]` holds byte 0 and `sta_hi[15:8]` holds byte 5.
- R4: In the first stage a broadcast frame is dropped when `bc_rej` is high. A multicast frame is dropped when `mc_rej` is high, even if it is in the table.
- R5: When `mc_rej` is low, a multicast frame passes the first stage only if it equals one of the MC_ENTRIES table entries. Entry i sits at `mc_tab[48i+47:48i]` in the same byte order as `frm_dst`.
- R6: The second stage acts only when `xf_en` and `xf_hash_en` are both high. In that stage a unicast frame must equal `{sta2_hi,sta2_lo}`, and a broadcast frame is dropped when `bc_rej` is high.
- R7: In the second stage a multicast frame starting 0x01,0x00,0x52 is dropped. Any other multicast frame builds the 15-bit index {byte4[6:0], byte5}. The frame is dropped unless bit index[4:0] of bitmap word index[14:5] is set. Bitmap words are written through `bmp_we`/`bmp_waddr`/`bmp_wdata`.
- R8: When `jumbo_en` and `vlan_en` are both low, frames of length 1519 to 1522 are dropped without the runt flag. Setting either enable lets them pass. Lengths of 1518 or less and 1523 or more are not affected by this rule.
- R9: A frame that passes every filter but is shorter than 12 bytes is not accepted and raises `dec_runt`. It also sets the sticky `rej_sts`, which stays set until a cycle with `rej_clr` high and no new runt.
- R10: While `rx_rst` is high or `rx_en` is low, no frame is accepted, `dec_runt` stays low and `rej_sts` is unchanged.
- R11: `dec_valid` is high exactly in the cycle after each `frm_valid` cycle. `dec_accept` and `dec_runt` are low whenever `dec_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| promisc | input | 1 | Skip the first filter stage |
| bc_rej | input | 1 | Reject broadcast frames |
| mc_rej | input | 1 | Reject multicast frames in the first stage |
| xf_en | input | 1 | Second-stage enable, part one |
| xf_hash_en | input | 1 | Second-stage enable, part two |
| jumbo_en | input | 1 | Jumbo frames allowed |
| vlan_en | input | 1 | VLAN-tagged lengths allowed |
| rx_rst | input | 1 | Receive path held in reset |
| rx_en | input | 1 | Receive path enabled |
| sta_lo | input | 32 | Station address bytes 0-3 |
| sta_hi | input | 16 | Station address bytes 4-5 |
| sta2_lo | input | 32 | Second station address bytes 0-3 |
| sta2_hi | input | 16 | Second station address bytes 4-5 |
| mc_tab | input | 48*MC_ENTRIES | Exact-match multicast table |
| bmp_we | input | 1 | Bitmap word write strobe |
| bmp_waddr | input | 10 | Bitmap word address |
| bmp_wdata | input | 32 | Bitmap word data |
| frm_valid | input | 1 | Frame descriptor valid |
| frm_dst | input | 48 | Destination bytes, byte 0 in bits 7:0 |
| frm_len | input | LEN_W | Frame length in bytes |
| rej_clr | input | 1 | Clear the sticky runt status |
| dec_valid | output | 1 | Verdict valid |
| dec_accept | output | 1 | Frame accepted |
| dec_runt | output | 1 | Frame rejected as runt |
| cls_ucast | output | 1 | Frame is unicast |
| cls_bcast | output | 1 | Frame is broadcast |
| cls_mcast | output | 1 | Frame is multicast |
| cls_ipmc | output | 1 | Frame is IP multicast |
| rej_sts | output | 1 | Sticky runt-reject status |

## Verification
On every cycle the assertions check the one-cycle verdict timing and that exactly one class is reported. They also check that a runt is never accepted and always leaves the status bit set, that gated receive yields no acceptance and no runt, and that short or oversize frames are never accepted. Whether the right address matched, which needs the configured station addresses, table entries and bitmap contents, can only be shown by the directed scenarios. The same holds for the order of the two stages and for which mode combinations allow a frame.

// File: rtl/rx_addr_filter.sv
`timescale 1ns/1ps
module rx_addr_filter #(
  parameter int MC_ENTRIES = 4,
  parameter int LEN_W      = 16,
  parameter int RUNT_MIN   = 12,
  parameter int STD_MAX    = 1518,
  parameter int VLAN_MAX   = 1522
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     promisc,
  input  logic                     bc_rej,
  input  logic                     mc_rej,
  input  logic                     xf_en,
  input  logic                     xf_hash_en,
  input  logic                     jumbo_en,
  input  logic                     vlan_en,
  input  logic                     rx_rst,
  input  logic                     rx_en,
  input  logic [31:0]              sta_lo,
  input  logic [15:0]              sta_hi,
  input  logic [31:0]              sta2_lo,
  input  logic [15:0]              sta2_hi,
  input  logic [48*MC_ENTRIES-1:0] mc_tab,
  input  logic                     bmp_we,
  input  logic [9:0]               bmp_waddr,
  input  logic [31:0]              bmp_wdata,
  input  logic                     frm_valid,
  input  logic [47:0]              frm_dst,
  input  logic [LEN_W-1:0]         frm_len,
  input  logic                     rej_clr,
  output logic                     dec_valid,
  output logic                     dec_accept,
  output logic                     dec_runt,
  output logic                     cls_ucast,
  output logic                     cls_bcast,
  output logic                     cls_mcast,
  output logic                     cls_ipmc,
  output logic                     rej_sts
);

  localparam int BMP_WORDS = 1024;
  localparam logic [LEN_W-1:0] L_RUNT = LEN_W'(RUNT_MIN);
  localparam logic [LEN_W-1:0] L_STD  = LEN_W'(STD_MAX);
  localparam logic [LEN_W-1:0] L_VLAN = LEN_W'(VLAN_MAX);

  logic [31:0] bmp [BMP_WORDS];

  always_ff @(posedge clk)
    if (bmp_we) bmp[bmp_waddr] <= bmp_wdata;

  logic is_uc, is_bc, is_mc, ipmc_pfx;
  assign is_uc    = ~frm_dst[0];
  assign is_bc    = &frm_dst;
  assign is_mc    = ~is_uc & ~is_bc;
  assign ipmc_pfx = (frm_dst[23:0] == 24'h520001);

  logic [MC_ENTRIES-1:0] mc_hits;
  for (genvar g = 0; g < MC_ENTRIES; g++) begin : g_mc
    assign mc_hits[g] = (mc_tab[48*g +: 48] == frm_dst);
  end

  logic uc_hit, uc2_hit;
  assign uc_hit  = ({sta_hi, sta_lo} == frm_dst);
  assign uc2_hit = ({sta2_hi, sta2_lo} == frm_dst);

  logic [14:0] hidx;
  logic [31:0] hword;
  logic        hbit;
  assign hidx  = {frm_dst[38:32], frm_dst[47:40]};
  assign hword = bmp[hidx[14:5]];
  assign hbit  = hword[hidx[4:0]];

  logic s1_pass, s2_pass, xf_on;
  assign s1_pass = promisc ||
                   (is_uc ? uc_hit : is_bc ? ~bc_rej : (~mc_rej && |mc_hits));
  assign xf_on   = xf_en & xf_hash_en;
  assign s2_pass = ~xf_on ||
                   (is_uc ? uc2_hit : is_bc ? ~bc_rej : (~ipmc_pfx && hbit));

  logic blocked, oversize, filt_ok, runt, accept;
  assign blocked  = rx_rst | ~rx_en;
  assign oversize = ~jumbo_en & ~vlan_en & (frm_len > L_STD) & (frm_len <= L_VLAN);
  assign filt_ok  = ~blocked & ~oversize & s1_pass & s2_pass;
  assign runt     = filt_ok & (frm_len < L_RUNT);
  assign accept   = filt_ok & ~runt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_runt   <= 1'b0;
      cls_ucast  <= 1'b0;
      cls_bcast  <= 1'b0;
      cls_mcast  <= 1'b0;
      cls_ipmc   <= 1'b0;
      rej_sts    <= 1'b0;
    end else begin
      dec_valid  <= frm_valid;
      dec_accept <= frm_valid & accept;
      dec_runt   <= frm_valid & runt;
      if (frm_valid) begin
        cls_ucast <= is_uc;
        cls_bcast <= is_bc;
        cls_mcast <= is_mc;
        cls_ipmc  <= is_mc & ipmc_pfx;
      end
      if (rej_clr) rej_sts <= 1'b0;
      if (frm_valid && runt) rej_sts <= 1'b1;
    end
  end

  // R11
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid |=> dec_valid);
  // R11
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !dec_valid && !dec_accept && !dec_runt);
  // R1
  class_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $countones({cls_ucast, cls_bcast, cls_mcast}) == 1);
  // R1
  ipmc_is_mc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && cls_ipmc |-> cls_mcast);
  // R9
  runt_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_runt |-> !dec_accept && rej_sts);
  // R9
  short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && frm_len < L_RUNT |=> !dec_accept);
  // R10
  gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && (rx_rst || !rx_en) |=> dec_valid && !dec_accept && !dec_runt);
  // R10
  gated_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && (rx_rst || !rx_en) && !rej_clr |=> rej_sts == $past(rej_sts));
  // R8
  oversize_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && !jumbo_en && !vlan_en && frm_len > L_STD && frm_len <= L_VLAN
      |=> !dec_accept && !dec_runt);

endmodule

// File: tb/tb_rx_addr_filter.sv
`timescale 1ns/1ps
module tb_rx_addr_filter;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic promisc, bc_rej, mc_rej, xf_en, xf_hash_en, jumbo_en, vlan_en, rx_rst, rx_en;
  logic [31:0] sta_lo, sta2_lo, bmp_wdata;
  logic [15:0] sta_hi, sta2_hi, frm_len;
  logic [191:0] mc_tab;
  logic bmp_we, frm_valid, rej_clr;
  logic [9:0] bmp_waddr;
  logic [47:0] frm_dst;
  logic dec_valid, dec_accept, dec_runt, cls_ucast, cls_bcast, cls_mcast, cls_ipmc, rej_sts;

  int checks = 0, failures = 0, cyc = 0;

  rx_addr_filter dut (.*);

  function automatic logic [47:0] mac(input logic [7:0] a, b, c, d, e, f);
    return {f, e, d, c, b, a};
  endfunction

  localparam logic [47:0] STA  = 48'h554433221102;
  localparam logic [47:0] STA2 = 48'h665544332206;
  localparam logic [47:0] BC   = 48'hFFFFFFFFFFFF;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [47:0] d, input logic [15:0] len);
    @(negedge clk);
    frm_dst = d; frm_len = len; frm_valid = 1;
    @(negedge clk);
    frm_valid = 0;
  endtask

  task automatic expect_dec(input string tag, input logic acc, input logic rn);
    check({tag, " valid"}, dec_valid, 1);
    check({tag, " accept"}, dec_accept, acc);
    check({tag, " runt"}, dec_runt, rn);
  endtask

  task automatic bmp_write(input logic [9:0] a, input logic [31:0] v);
    @(negedge clk);
    bmp_we = 1; bmp_waddr = a; bmp_wdata = v;
    @(negedge clk);
    bmp_we = 0;
  endtask

  task automatic defaults;
    promisc = 0; bc_rej = 0; mc_rej = 0; xf_en = 0; xf_hash_en = 0;
    jumbo_en = 0; vlan_en = 0; rx_rst = 0; rx_en = 1;
  endtask

  task automatic t_reset;
    check("R11 reset valid", dec_valid, 0);
    check("R11 reset accept", dec_accept, 0);
    check("R9 reset sts", rej_sts, 0);
  endtask

  task automatic t_unicast;
    defaults();
    send(STA, 64);
    expect_dec("R3 uc match", 1, 0);
    check("R1 uc class", {cls_ucast, cls_bcast, cls_mcast, cls_ipmc}, 4'b1000);
    send(mac(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56), 64);
    expect_dec("R3 uc miss", 0, 0);
    @(negedge clk);
    check("R11 idle after", dec_valid, 0);
  endtask

  task automatic t_broadcast;
    defaults();
    send(BC, 64);
    expect_dec("R4 bc pass", 1, 0);
    check("R1 bc class", {cls_ucast, cls_bcast, cls_mcast, cls_ipmc}, 4'b0100);
    bc_rej = 1;
    send(BC, 64);
    expect_dec("R4 bc rej", 0, 0);
  endtask

  task automatic t_multicast;
    defaults();
    send(mac(8'h01, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'h02), 64);
    expect_dec("R5 mc entry2", 1, 0);
    check("R1 mc class", {cls_ucast, cls_bcast, cls_mcast, cls_ipmc}, 4'b0010);
    send(mac(8'h01, 8'h00, 8'h52, 8'h01, 8'h02, 8'h03), 64);
    expect_dec("R5 mc entry3", 1, 0);
    check("R1 ipmc class", {cls_ucast, cls_bcast, cls_mcast, cls_ipmc}, 4'b0011);
    send(mac(8'h01, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'h09), 64);
    expect_dec("R5 mc absent", 0, 0);
    mc_rej = 1;
    send(mac(8'h01, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'h02), 64);
    expect_dec("R4 mc rej", 0, 0);
  endtask

  task automatic t_promisc;
    defaults();
    promisc = 1; mc_rej = 1; bc_rej = 1;
    send(mac(8'h04, 8'h04, 8'h04, 8'h04, 8'h04, 8'h04), 64);
    expect_dec("R2 promisc uc", 1, 0);
    send(mac(8'h01, 8'h77, 8'h77, 8'h77, 8'h77, 8'h77), 64);
    expect_dec("R2 promisc mc", 1, 0);
    send(BC, 64);
    expect_dec("R2 promisc bc", 1, 0);
  endtask

  task automatic t_stage2;
    logic [47:0] hm;
    logic [14:0] ix;
    defaults();
    xf_en = 1;
    send(STA, 64);
    expect_dec("R6 one enable", 1, 0);
    xf_hash_en = 1;
    send(STA, 64);
    expect_dec("R6 uc2 miss", 0, 0);
    promisc = 1;
    send(STA2, 64);
    expect_dec("R6 uc2 hit", 1, 0);
    bc_rej = 1;
    send(BC, 64);
    expect_dec("R6 bc rej again", 0, 0);
    promisc = 0; bc_rej = 0;
    send(mac(8'h01, 8'h00, 8'h52, 8'h01, 8'h02, 8'h03), 64);
    expect_dec("R7 ipmc drop", 0, 0);
    hm = mac(8'h01, 8'hAA, 8'hBB, 8'hCC, 8'h85, 8'h3C);
    mc_tab[47:0] = hm;
    ix = {hm[38:32], hm[47:40]};
    bmp_write(ix[14:5], 32'h0);
    send(hm, 64);
    expect_dec("R7 hash clear", 0, 0);
    bmp_write(ix[14:5], 32'h1 << ix[4:0]);
    send(hm, 64);
    expect_dec("R7 hash set", 1, 0);
    bmp_write(ix[14:5], ~(32'h1 << ix[4:0]));
    send(hm, 64);
    expect_dec("R7 other bits", 0, 0);
  endtask

  task automatic t_oversize;
    defaults();
    send(STA, 1520);
    expect_dec("R8 1520 drop", 0, 0);
    send(STA, 1519);
    expect_dec("R8 1519 drop", 0, 0);
    send(STA, 1522);
    expect_dec("R8 1522 drop", 0, 0);
    send(STA, 1518);
    expect_dec("R8 1518 pass", 1, 0);
    send(STA, 1523);
    expect_dec("R8 1523 pass", 1, 0);
    vlan_en = 1;
    send(STA, 1520);
    expect_dec("R8 vlan pass", 1, 0);
    vlan_en = 0; jumbo_en = 1;
    send(STA, 1520);
    expect_dec("R8 jumbo pass", 1, 0);
  endtask

  task automatic t_runt;
    defaults();
    send(STA, 11);
    expect_dec("R9 runt", 0, 1);
    check("R9 sts set", rej_sts, 1);
    send(STA, 12);
    expect_dec("R9 min len", 1, 0);
    check("R9 sts sticky", rej_sts, 1);
    @(negedge clk); rej_clr = 1;
    @(negedge clk); rej_clr = 0;
    check("R9 sts clr", rej_sts, 0);
    send(mac(8'h02, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00), 5);
    expect_dec("R9 filtered short", 0, 0);
    check("R9 sts untouched", rej_sts, 0);
  endtask

  task automatic t_gate;
    defaults();
    rx_rst = 1;
    send(STA, 64);
    expect_dec("R10 rx_rst", 0, 0);
    rx_rst = 0; rx_en = 0;
    send(STA, 5);
    expect_dec("R10 rx_en off runt", 0, 0);
    check("R10 sts kept", rej_sts, 0);
    rx_en = 1;
    send(STA, 64);
    expect_dec("R10 resumed", 1, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    defaults();
    sta_lo = STA[31:0]; sta_hi = STA[47:32];
    sta2_lo = STA2[31:0]; sta2_hi = STA2[47:32];
    mc_tab = '0;
    mc_tab[48*2 +: 48] = mac(8'h01, 8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'h02);
    mc_tab[48*3 +: 48] = mac(8'h01, 8'h00, 8'h52, 8'h01, 8'h02, 8'h03);
    bmp_we = 0; bmp_waddr = '0; bmp_wdata = '0;
    frm_valid = 0; frm_dst = '0; frm_len = '0; rej_clr = 0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_unicast();
    t_broadcast();
    t_multicast();
    t_promisc();
    t_stage2();
    t_oversize();
    t_runt();
    t_gate();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule